// File: doc/BRIEF.md
# Shared Control Channel First-Slot Encoder

This block builds the 40-bit field that occupies the first slot of a downlink shared control subframe. A single start strobe captures a 7-bit code-set value, a 1-bit modulation flag and a 16-bit terminal identity. The block first derives a 40-bit scrambling mask from the identity. It then encodes the 8 information bits with a terminated rate-1/3 convolutional code of constraint length 9. It deletes 8 fixed coded positions from each 48-bit stream and emits the 40 surviving data bits, each XORed with the matching mask bit, one per beat.

The work runs serially. The mask phase takes 48 cycles and the data phase takes 48 cycles. In 8 cycles of the data phase the current coded bit is punctured, so no beat appears. The downstream modulator takes beats while `ser_valid` is high, uses `ser_last` to close the field, and waits for `done` before it issues the next start. A start that arrives while a job is in flight is dropped, and the event is recorded in a sticky flag.

Top module: `ctl1_encoder`

## Requirements
- R1: The data encoder is fed ccs_in[6] first, then ccs_in[5] down to ccs_in[0], then mod_in, then 8 zero tail bits (16 steps in all), using the values captured at the accepted start.
- R2: At data step t the encoder yields three coded bits, from octal generators 557, 663 and 711 in that order, at 0-based coded position 3t+g. The bit for generator G is the XOR over d=0..8 of G[8-d] AND u[t-d], where u is the step input and u before step 0 is zero.
- R3: Coded positions 0, 1, 3, 7, 41, 44, 46 and 47 (0-based) are removed from the 48-bit data stream and from the 48-bit mask stream, and 40 bits survive in each.
- R4: The mask stream comes from encoding ue_id[15] first down to ue_id[0], then 8 zero tail bits (24 steps), with octal generators 561 then 753 under the tap rule of R2, at position 2t+g. It is then punctured as in R3.
- R5: Each job produces exactly 40 beats with ser_valid high. Beat k (k = 1..40, in ascending order) carries surviving data bit k XOR surviving mask bit k.
- R6: ser_last is high together with the 40th beat and at no other time.
- R7: done is a one-cycle pulse, once per job, after the 40th beat. busy is low in that cycle, and a start in that cycle is accepted.
- R8: A start while busy is high does not alter the running job's output and sets overrun.
- R9: Once set, overrun stays high until reset.
- R10: After reset, busy, ser_valid, ser_last, done and overrun are all low.
- R11: busy goes high in the cycle after an accepted start and stays high until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, accepted when idle |
| ccs_in | input | 7 | Channelization code-set value |
| mod_in | input | 1 | Modulation flag |
| ue_id | input | 16 | Terminal identity used for the mask |
| busy | output | 1 | A job is in flight |
| ser_bit | output | 1 | Scrambled output bit |
| ser_valid | output | 1 | ser_bit carries a beat |
| ser_last | output | 1 | Beat is the 40th of the field |
| done | output | 1 | One-cycle job completion pulse |
| overrun | output | 1 | Sticky flag: a start was dropped while busy |

## Verification
The hardest case to reach from the ports is a start that lands in the middle of a job and carries different operands. A design that re-latches those operands, or restarts its counters, would still emit 40 plausible-looking beats. The bench raises start a few cycles into a job with every operand bit inverted. It then compares the whole field with the arithmetic result for the original operands and confirms that overrun is set and stays set through the next clean job. Sweeping all 256 information words and every single-bit identity brings each generator tap and each surviving position into play in both encoders.

// File: rtl/ctl1_pkg.sv
package ctl1_pkg;

    localparam int CCS_W      = 7;
    localparam int UE_W       = 16;
    localparam int INFO_W     = CCS_W + 1;
    localparam int CL         = 9;
    localparam int MEM_W      = CL - 1;
    localparam int DATA_RATE  = 3;
    localparam int MASK_RATE  = 2;
    localparam int DATA_STEPS = INFO_W + MEM_W;
    localparam int MASK_STEPS = UE_W + MEM_W;
    localparam int CODED_LEN  = DATA_RATE * DATA_STEPS;
    localparam int OUT_LEN    = 40;
    localparam int CNT_W      = $clog2(CODED_LEN);
    localparam int KCNT_W     = $clog2(OUT_LEN + 1);
    localparam int GEN_W      = $clog2(DATA_RATE);
    localparam int SRC_W      = UE_W;

    // Generator 0 sits in the lowest slice.
    localparam logic [DATA_RATE*CL-1:0] DATA_GENS = {9'o711, 9'o663, 9'o557};
    localparam logic [MASK_RATE*CL-1:0] MASK_GENS = {9'o753, 9'o561};

    // Bit j set means coded position j is deleted.
    localparam logic [CODED_LEN-1:0] PUNCT_MAP = 48'hD200_0000_008B;

    localparam logic [CNT_W-1:0]  CNT_LAST   = CNT_W'(CODED_LEN - 1);
    localparam logic [KCNT_W-1:0] OUT_LAST   = KCNT_W'(OUT_LEN - 1);
    localparam logic [GEN_W-1:0]  DATA_GLAST = GEN_W'(DATA_RATE - 1);
    localparam logic [GEN_W-1:0]  MASK_GLAST = GEN_W'(MASK_RATE - 1);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_MASK,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic [CCS_W-1:0] ccs;
        logic             modf;
    } job_t;

    function automatic logic pos_kept(input logic [CNT_W-1:0] j);
        if (32'(j) >= CODED_LEN) return 1'b0;
        return !PUNCT_MAP[j];
    endfunction

    function automatic logic [SRC_W-1:0] data_src(input job_t jb);
        return {jb.ccs, jb.modf, {(SRC_W-INFO_W){1'b0}}};
    endfunction

endpackage

// File: rtl/ctl1_conv.sv
module ctl1_conv
    import ctl1_pkg::*;
#(
    parameter int                    N_GEN = 3,
    parameter logic [N_GEN*CL-1:0]   GENS  = DATA_GENS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic             in_bit,
    input  logic [GEN_W-1:0] sel,
    output logic             coded
);

    logic [MEM_W-1:0] hist_q;   // [MEM_W-1] is the most recent input
    logic [CL-1:0]    window;
    logic [N_GEN-1:0] par;

    assign window = {in_bit, hist_q};

    generate
        for (genvar g = 0; g < N_GEN; g++) begin : g_tap
            assign par[g] = ^(window & GENS[g*CL +: CL]);
        end
    endgenerate

    always_comb begin
        coded = 1'b0;
        for (int i = 0; i < N_GEN; i++) begin
            if (sel == GEN_W'(i)) coded = par[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hist_q <= '0;
        end else if (adv) begin
            hist_q <= {in_bit, hist_q[MEM_W-1:1]};
        end
    end

endmodule

// File: rtl/ctl1_mask_reg.sv
module ctl1_mask_reg #(
    parameter int LEN = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic push_bit,
    input  logic pop,
    output logic head
);

    logic [LEN-1:0] q;

    assign head = q[LEN-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (push) begin
            q <= {q[LEN-2:0], push_bit};
        end else if (pop) begin
            q <= {q[LEN-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/ctl1_encoder.sv
module ctl1_encoder
    import ctl1_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CCS_W-1:0] ccs_in,
    input  logic             mod_in,
    input  logic [UE_W-1:0]  ue_id,
    output logic             busy,
    output logic             ser_bit,
    output logic             ser_valid,
    output logic             ser_last,
    output logic             done,
    output logic             overrun
);

    phase_e            phase_q;
    job_t              job_q;
    logic [SRC_W-1:0]  src_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [GEN_W-1:0]  gen_q;
    logic [KCNT_W-1:0] kcnt_q;
    logic              bit_q, valid_q, last_q, done_q, ovr_q;

    logic accept, in_mask, in_data, last_gen, kept_now;
    logic mask_coded, data_coded, mask_head;

    assign accept   = start && (phase_q == PH_IDLE);
    assign in_mask  = (phase_q == PH_MASK);
    assign in_data  = (phase_q == PH_DATA);
    assign last_gen = in_mask ? (gen_q == MASK_GLAST) : (gen_q == DATA_GLAST);
    assign kept_now = pos_kept(cnt_q);

    ctl1_conv #(.N_GEN(MASK_RATE), .GENS(MASK_GENS)) u_mask_conv (
        .clk    (clk),
        .rst    (rst),
        .clr    (accept),
        .adv    (in_mask && last_gen),
        .in_bit (src_q[SRC_W-1]),
        .sel    (gen_q),
        .coded  (mask_coded)
    );

    ctl1_conv #(.N_GEN(DATA_RATE), .GENS(DATA_GENS)) u_data_conv (
        .clk    (clk),
        .rst    (rst),
        .clr    (accept),
        .adv    (in_data && last_gen),
        .in_bit (src_q[SRC_W-1]),
        .sel    (gen_q),
        .coded  (data_coded)
    );

    ctl1_mask_reg #(.LEN(OUT_LEN)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .push     (in_mask && kept_now),
        .push_bit (mask_coded),
        .pop      (in_data && kept_now),
        .head     (mask_head)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            job_q   <= '0;
            src_q   <= '0;
            cnt_q   <= '0;
            gen_q   <= '0;
            kcnt_q  <= '0;
            bit_q   <= 1'b0;
            valid_q <= 1'b0;
            last_q  <= 1'b0;
            done_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            last_q  <= 1'b0;
            done_q  <= 1'b0;
            if (start && phase_q != PH_IDLE) ovr_q <= 1'b1;

            if (phase_q != PH_IDLE) begin
                if (last_gen) begin
                    gen_q <= '0;
                    src_q <= {src_q[SRC_W-2:0], 1'b0};
                end else begin
                    gen_q <= gen_q + 1'b1;
                end
                cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
            end

            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        job_q   <= '{ccs: ccs_in, modf: mod_in};
                        src_q   <= ue_id;
                        cnt_q   <= '0;
                        gen_q   <= '0;
                        kcnt_q  <= '0;
                        phase_q <= PH_MASK;
                    end
                end
                PH_MASK: begin
                    if (cnt_q == CNT_LAST) begin
                        gen_q   <= '0;
                        src_q   <= data_src(job_q);
                        phase_q <= PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (kept_now) begin
                        valid_q <= 1'b1;
                        bit_q   <= data_coded ^ mask_head;
                        last_q  <= (kcnt_q == OUT_LAST);
                        kcnt_q  <= kcnt_q + 1'b1;
                    end
                    if (cnt_q == CNT_LAST) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy      = (phase_q != PH_IDLE);
    assign ser_bit   = bit_q;
    assign ser_valid = valid_q;
    assign ser_last  = last_q;
    assign done      = done_q;
    assign overrun   = ovr_q;

endmodule

// File: rtl/ctl1_checker.sv
module ctl1_checker (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic ser_valid,
    input logic ser_last,
    input logic done,
    input logic overrun
);

    logic [6:0] beats_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beats_q <= '0;
        end else if (start && !busy) begin
            beats_q <= '0;
        end else if (ser_valid) begin
            beats_q <= beats_q + 1'b1;
        end
    end

    assert_last_in_beat_R6: assert property (@(posedge clk) disable iff (rst)
        ser_last |-> ser_valid);

    assert_last_is_fortieth_R6: assert property (@(posedge clk) disable iff (rst)
        ser_last |-> (beats_q == 7'd39));

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_forty_beats_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (beats_q == 7'd40));

    assert_beats_only_busy_R5: assert property (@(posedge clk) disable iff (rst)
        ser_valid |-> busy);

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(start && busy));

    assert_busy_after_start_R11: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_busy_until_done_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

endmodule

bind ctl1_encoder ctl1_checker u_ctl1_checker (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .ser_valid (ser_valid),
    .ser_last  (ser_last),
    .done      (done),
    .overrun   (overrun)
);

// File: tb/ctl1_encoder_test.sv
module ctl1_encoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [6:0]  ccs_in = '0;
    logic        mod_in = 1'b0;
    logic [15:0] ue_id = '0;
    logic        busy, ser_bit, ser_valid, ser_last, done, overrun;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ctl1_encoder uut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ccs_in    (ccs_in),
        .mod_in    (mod_in),
        .ue_id     (ue_id),
        .busy      (busy),
        .ser_bit   (ser_bit),
        .ser_valid (ser_valid),
        .ser_last  (ser_last),
        .done      (done),
        .overrun   (overrun)
    );

    function automatic logic [8:0] gdata(input int g);
        case (g)
            0:       return 9'o557;
            1:       return 9'o663;
            default: return 9'o711;
        endcase
    endfunction

    function automatic logic [8:0] gmask(input int g);
        return (g == 0) ? 9'o561 : 9'o753;
    endfunction

    function automatic bit deleted(input int j);
        return j == 0 || j == 1 || j == 3 || j == 7 || j == 41 || j == 44 || j == 46 || j == 47;
    endfunction

    // Field in arrival order: first beat lands in bit 39.
    function automatic logic [39:0] model(input logic [6:0] c, input logic m, input logic [15:0] u);
        logic [7:0]  info;
        logic [47:0] dcod, mcod;
        logic [39:0] dk, mk, res;
        logic [8:0]  gv;
        logic        b;
        int          k;
        info = {c, m};
        dcod = '0;
        mcod = '0;
        dk = '0;
        mk = '0;
        res = '0;
        for (int t = 0; t < 16; t++) begin
            for (int g = 0; g < 3; g++) begin
                gv = gdata(g);
                b = 1'b0;
                for (int d = 0; d < 9; d++)
                    if (t - d >= 0 && t - d < 8 && gv[8-d]) b ^= info[7-(t-d)];
                dcod[3*t+g] = b;
            end
        end
        for (int t = 0; t < 24; t++) begin
            for (int g = 0; g < 2; g++) begin
                gv = gmask(g);
                b = 1'b0;
                for (int d = 0; d < 9; d++)
                    if (t - d >= 0 && t - d < 16 && gv[8-d]) b ^= u[15-(t-d)];
                mcod[2*t+g] = b;
            end
        end
        k = 0;
        for (int j = 0; j < 48; j++) begin
            if (!deleted(j)) begin
                dk[k] = dcod[j];
                mk[k] = mcod[j];
                k++;
            end
        end
        for (int q = 0; q < 40; q++) res[39-q] = dk[q] ^ mk[q];
        return res;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_job(input logic [6:0] c, input logic m, input logic [15:0] u,
                           input int inject_at,
                           output logic [39:0] word, output int beats, output int last_at,
                           output bit done_seen, output bit busy_at_done, output bit busy_first);
        @(negedge clk);
        ccs_in = c; mod_in = m; ue_id = u; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        word = '0; beats = 0; last_at = -1; done_seen = 0; busy_at_done = 1; busy_first = busy;
        for (int cyc = 0; cyc < 400 && !done_seen; cyc++) begin
            if (cyc == inject_at) begin
                ccs_in = ~c; mod_in = ~m; ue_id = ~u; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (ser_valid) begin
                word = {word[38:0], ser_bit};
                beats++;
                if (ser_last) last_at = beats;
            end
            if (done) begin
                done_seen = 1;
                busy_at_done = busy;
            end
            if (!done_seen) @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic job_and_check(input logic [6:0] c, input logic m, input logic [15:0] u,
                                 input string req);
        logic [39:0] w, e;
        int nb, la;
        bit ds, bd, bf;
        run_job(c, m, u, -1, w, nb, la, ds, bd, bf);
        e = model(c, m, u);
        check(w == e, req, "field", 64'(w), 64'(e));
        check(nb == 40 && la == 40, "R6", "beats/last", 64'(nb * 256 + la), 64'(40 * 256 + 40));
        check(ds && !bd, "R7", "done with busy low", 64'({ds, bd}), 64'(2'b10));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R7 watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [39:0] w, e;
        int nb, la;
        bit ds, bd, bf;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: quiet outputs after reset
        check(!busy, "R10", "busy", 64'(busy), 64'(0));
        check(!ser_valid && !ser_last, "R10", "valid/last", 64'({ser_valid, ser_last}), 64'(0));
        check(!done, "R10", "done", 64'(done), 64'(0));
        check(!overrun, "R10", "overrun", 64'(overrun), 64'(0));

        // R11: busy right after accept, R1 R2 R3 R5 field
        run_job(7'h55, 1'b1, 16'h1234, -1, w, nb, la, ds, bd, bf);
        check(bf, "R11", "busy after start", 64'(bf), 64'(1));
        e = model(7'h55, 1'b1, 16'h1234);
        check(w == e, "R1 R2 R5", "directed field", 64'(w), 64'(e));

        // All information words, fixed identity: R1 R2 R3 R5
        for (int i = 0; i < 256; i++)
            job_and_check(7'(i >> 1), i[0], 16'hA5C3, "R1 R2 R3 R5");

        // Identity sweep: R4 mask generation and puncturing
        for (int i = 0; i < 18; i++) begin
            logic [15:0] uu;
            uu = (i < 16) ? (16'h1 << i) : ((i == 16) ? 16'h0000 : 16'hFFFF);
            job_and_check(7'h2D, 1'b0, uu, "R4 R3");
        end

        // R8: start mid-job with inverted operands
        check(!overrun, "R9", "overrun before", 64'(overrun), 64'(0));
        run_job(7'h3A, 1'b0, 16'hC0DE, 3, w, nb, la, ds, bd, bf);
        e = model(7'h3A, 1'b0, 16'hC0DE);
        check(w == e, "R8", "field under ignored start", 64'(w), 64'(e));
        check(nb == 40, "R8", "beats under ignored start", 64'(nb), 64'(40));
        check(overrun, "R8", "overrun set", 64'(overrun), 64'(1));

        // R9: sticky through a clean job
        job_and_check(7'h11, 1'b1, 16'h0F0F, "R5");
        check(overrun, "R9", "overrun held", 64'(overrun), 64'(1));

        // R7: start in the done cycle is accepted
        @(negedge clk);
        ccs_in = 7'h60; mod_in = 1'b0; ue_id = 16'h8001; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        ccs_in = 7'h07; mod_in = 1'b1; ue_id = 16'h7FFE; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R7", "start in done cycle accepted", 64'(busy), 64'(1));
        w = '0; nb = 0;
        while (!done) begin
            if (ser_valid) begin w = {w[38:0], ser_bit}; nb++; end
            @(negedge clk);
        end
        e = model(7'h07, 1'b1, 16'h7FFE);
        check(w == e && nb == 40, "R7", "back-to-back field", 64'(w), 64'(e));

        // R10 R9: reset clears overrun
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!overrun && !busy, "R10", "overrun after reset", 64'({overrun, busy}), 64'(0));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule